// File: doc/BRIEF.md
# MDIO Management Master with Host Register Interface

This block lets a host processor run Clause 22 management transactions on a PHY management bus. The host sees three 16-bit registers on a small synchronous register port. A single write to the command register names the PHY, the register inside it and the direction, and starts the frame at once. Outgoing data is staged beforehand in a separate transmit register. Incoming data shows up in a separate receive register once the frame has ended.

The engine generates the management clock from the system clock and emits a 64-bit frame: 32 preamble ones, the start pattern 01, a two-bit opcode, the PHY and register addresses, a two-bit turnaround and sixteen data bits, most significant bit first. On reads it releases the data line for the turnaround and data fields and samples the PHY on rising management-clock edges. Completion is reported only through an idle flag that the host polls. At the default rates a frame takes 25.6 µs, well inside the 100 µs the driver allows.

Top module: `mdio_master`

## Requirements
- R1: The register port decodes `host_sel` as 0 = command/status, 1 = transmit data, 2 = receive data, 3 = unused (reads 0). `host_rdata` follows `host_sel` combinationally. A write with `host_sel`=1 stores `host_wdata` in the transmit register.
- R2: The command word carries the register number in bits 4:0, the PHY address in bits 9:5 and the opcode in bits 11:10. Reading it returns those fields from the last accepted command, the idle flag in bit 12, and zeros in bits 15:13.
- R3: Opcode 2 starts a read and opcode 1 starts a write. A command write with opcode 0 or 3 starts nothing, leaves the stored command unchanged and keeps the idle flag at 1.
- R4: A command write that arrives while a frame is in progress is ignored. The running frame and the stored command are unchanged.
- R5: Each frame sends 32 ones, then 01, the opcode, the 5-bit PHY address, the 5-bit register address, the turnaround and 16 data bits, MSB first. A write drives all 64 bits, with turnaround 10 and the transmit register as data.
- R6: A read drives only the first 46 bits. It sets `mdio_oe` low for the turnaround and data bits and samples `mdio_i` on each rising MDC edge of the 16 data bits.
- R7: An MDC half period lasts ceil(CLK_HZ / (2·MDC_HZ)) system clocks (10 at defaults, giving 2.5 MHz). MDC goes low in the cycle after a command is accepted. `mdio_o` changes only together with a falling MDC edge, and a frame spans 64 MDC periods.
- R8: The receive register keeps its value until a read frame finishes. It then takes all 16 captured bits at once, in the same cycle the idle flag returns.
- R9: Synchronous reset makes the engine idle, sets `mdio_oe` low and MDC high, and clears the stored command and both data registers. The command register then reads 0x1000.
- R10: The idle flag reads 0 from the cycle after a command is accepted until the end of the last MDC high phase. It reads 1 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Register select |
| host_we | input | 1 | Register write strobe |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable (high = drive) |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
The assertions assume reset is asserted in the first clock cycle and that the host makes at most one register access per cycle, so a command write and a transmit-data write never coincide. They make no claim about `mdio_i`, because the engine only looks at it during read data bits. The stimulus drives the register port a few nanoseconds after each rising edge and holds it for a full cycle. The PHY model drives `mdio_i` only from the falling system-clock edge, so every sampled bit is settled well before the MDC rising edge that captures it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int PRE_BITS   = 32;
    localparam int HOST_W     = 16;

    // number of bits the master drives during a read (preamble..register address)
    localparam int DRIVE_BITS_READ = PRE_BITS + 2 + 2 + 2 * ADDR_W;

    // command word layout, decoded by host software
    localparam int REG_LSB  = 0;
    localparam int PHY_LSB  = 5;
    localparam int OP_LSB   = 10;
    localparam int IDLE_BIT = 12;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RSVD  = 2'd3
    } mdio_op_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_WDATA = 2'd1,
        SEL_RDATA = 2'd2,
        SEL_NONE  = 2'd3
    } host_sel_e;

    typedef struct packed {
        mdio_op_e          op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
    } mdio_cmd_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c,
                                                          logic [DATA_W-1:0] wd);
        logic [1:0]        ta;
        logic [DATA_W-1:0] body;
        ta   = (c.op == OP_WRITE) ? 2'b10 : 2'b11;
        body = (c.op == OP_WRITE) ? wd : {DATA_W{1'b1}};
        return {{PRE_BITS{1'b1}}, 2'b01, c.op, c.phy, c.regn, ta, body};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic run,
    output logic mdc,
    output logic at_rise,
    output logic at_fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] WRAP_VAL = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          mdc_q;
    logic          wrap;

    assign wrap    = run && (cnt == WRAP_VAL);
    assign at_rise = wrap && !mdc_q;
    assign at_fall = wrap && mdc_q;
    assign mdc     = mdc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            mdc_q <= 1'b1;
        end else if (start) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (stop) begin
            cnt   <= '0;
            mdc_q <= 1'b1;
        end else if (run) begin
            if (wrap) begin
                cnt   <= '0;
                mdc_q <= ~mdc_q;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  rd_in,
    input  logic                  at_rise,
    input  logic                  at_fall,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  last,
    output logic                  rd_done,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic [DATA_W-1:0]     rx_data
);
    localparam int BCW = $clog2(FRAME_BITS);
    localparam logic [BCW-1:0] LAST_IDX = BCW'(FRAME_BITS - 1);
    localparam logic [BCW-1:0] REL_IDX  = BCW'(DRIVE_BITS_READ);
    localparam logic [BCW-1:0] CAP_IDX  = BCW'(FRAME_BITS - DATA_W);

    logic [FRAME_BITS-1:0] sh;
    logic [BCW-1:0]        bitc;
    logic                  busy_q;
    logic                  rd_q;
    logic [DATA_W-1:0]     rx_q;

    assign busy    = busy_q;
    assign last    = busy_q && at_fall && (bitc == LAST_IDX);
    assign rd_done = last && rd_q;
    assign mdio_o  = busy_q ? sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = busy_q && (!rd_q || (bitc < REL_IDX));
    assign rx_data = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            bitc   <= '0;
            sh     <= '1;
            rx_q   <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            rd_q   <= rd_in;
            bitc   <= '0;
            sh     <= frame_in;
        end else if (busy_q) begin
            if (at_fall) begin
                if (bitc == LAST_IDX) begin
                    busy_q <= 1'b0;
                end else begin
                    sh   <= sh << 1;
                    bitc <= bitc + 1'b1;
                end
            end
            if (at_rise && rd_q && (bitc >= CAP_IDX)) begin
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            end
        end
    end

    AST_RX_ONLY_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (busy_q && rd_q && at_rise && (bitc >= CAP_IDX)) |-> !mdio_oe); // R6

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            host_sel,
    input  logic                  host_we,
    input  logic [HOST_W-1:0]     host_wdata,
    input  logic                  busy,
    input  logic                  rd_done,
    input  logic [DATA_W-1:0]     rx_data,
    output logic                  start,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  rd_req,
    output logic [HOST_W-1:0]     host_rdata
);
    mdio_cmd_t         cmd_q;
    mdio_cmd_t         cmd_new;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_q;
    logic              ctrl_hit;
    logic              op_ok;
    host_sel_e         sel;

    assign sel = host_sel_e'(host_sel);

    always_comb begin
        cmd_new.op   = mdio_op_e'(host_wdata[OP_LSB +: 2]);
        cmd_new.phy  = host_wdata[PHY_LSB +: ADDR_W];
        cmd_new.regn = host_wdata[REG_LSB +: ADDR_W];
    end

    assign op_ok    = (cmd_new.op == OP_WRITE) || (cmd_new.op == OP_READ);
    assign ctrl_hit = host_we && (sel == SEL_CTRL);
    assign start    = ctrl_hit && !busy && op_ok;
    assign frame    = build_frame(cmd_new, wd_q);
    assign rd_req   = (cmd_new.op == OP_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '{op: OP_NONE, phy: '0, regn: '0};
            wd_q  <= '0;
            rd_q  <= '0;
        end else begin
            if (start) begin
                cmd_q <= cmd_new;
            end
            if (host_we && (sel == SEL_WDATA)) begin
                wd_q <= host_wdata;
            end
            if (rd_done) begin
                rd_q <= rx_data;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                host_rdata[IDLE_BIT]              = !busy;
                host_rdata[OP_LSB +: 2]           = cmd_q.op;
                host_rdata[PHY_LSB +: ADDR_W]     = cmd_q.phy;
                host_rdata[REG_LSB +: ADDR_W]     = cmd_q.regn;
            end
            SEL_WDATA: host_rdata = wd_q;
            SEL_RDATA: host_rdata = rd_q;
            default:   host_rdata = '0;
        endcase
    end

    AST_BADOP_NO_START: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && !busy && !op_ok) |=> !busy); // R3
    AST_BUSY_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && busy) |=> $stable(cmd_q)); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_done |=> $stable(rd_q)); // R8
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R10

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int MDC_HZ = 2_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        host_sel,
    input  logic              host_we,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int HALF_RAW = (CLK_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ);
    localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

    logic                  start;
    logic                  busy;
    logic                  last;
    logic                  rd_done;
    logic                  rd_req;
    logic                  at_rise;
    logic                  at_fall;
    logic [FRAME_BITS-1:0] frame;
    logic [DATA_W-1:0]     rx_data;

    mdio_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .busy       (busy),
        .rd_done    (rd_done),
        .rx_data    (rx_data),
        .start      (start),
        .frame      (frame),
        .rd_req     (rd_req),
        .host_rdata (host_rdata)
    );

    mdio_clkgen #(.HALF(HALF)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .stop    (last),
        .run     (busy),
        .mdc     (mdc),
        .at_rise (at_rise),
        .at_fall (at_fall)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .frame_in (frame),
        .rd_in    (rd_req),
        .at_rise  (at_rise),
        .at_fall  (at_fall),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .last     (last),
        .rd_done  (rd_done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rx_data  (rx_data)
    );

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mdc && !mdio_oe)); // R9
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc)); // R7

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int CLK_HZ = 50_000_000;
    localparam int MDC_HZ = 2_500_000;
    localparam int H      = (CLK_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ);
    localparam int P      = 2 * H;
    localparam int FL     = 64 * P;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [15:0] host_wdata = 16'h0;
    logic        mdio_i = 1'b1;
    wire  [15:0] host_rdata;
    wire         mdc;
    wire         mdio_o;
    wire         mdio_oe;

    int compared   = 0;
    int mismatched = 0;
    int wd_cnt     = 0;
    bit finished   = 0;

    always #10ns clk = ~clk;

    mdio_master #(.CLK_HZ(CLK_HZ), .MDC_HZ(MDC_HZ)) u0 (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // behavioural reference state
    bit          m_busy;
    int          m_t;
    bit          m_rd;
    logic [63:0] m_frame;
    logic [1:0]  m_op;
    logic [4:0]  m_phy, m_reg;
    logic [15:0] m_wd, m_rdreg;
    logic [15:0] phy_val = 16'h0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    always @(posedge clk) begin
        logic acc;
        if (rst) begin
            m_busy = 0; m_t = 0; m_rd = 0; m_op = 0; m_phy = 0; m_reg = 0;
            m_wd = 0; m_rdreg = 0; m_frame = '1;
        end else begin
            acc = host_we && (host_sel == 2'd0) && !m_busy &&
                  ((host_wdata[11:10] == 2'd1) || (host_wdata[11:10] == 2'd2));
            if (host_we && host_sel == 2'd1) m_wd = host_wdata;
            if (m_busy) begin
                if (m_t == FL) begin
                    m_busy = 0;
                    if (m_rd) m_rdreg = phy_val;
                end else begin
                    m_t++;
                end
            end
            if (acc) begin
                m_busy  = 1;
                m_t     = 1;
                m_op    = host_wdata[11:10];
                m_phy   = host_wdata[9:5];
                m_reg   = host_wdata[4:0];
                m_rd    = (m_op == 2'd2);
                m_frame = {32'hFFFF_FFFF, 2'b01, m_op, m_phy, m_reg,
                           m_rd ? 2'b11 : 2'b10, m_rd ? 16'hFFFF : m_wd};
            end
        end
    end

    // compare every cycle at the falling edge, then present the PHY bit
    always @(negedge clk) begin
        int k, ph;
        logic e_mdc, e_oe;
        logic [15:0] e_rd;
        k = (m_t - 1) / P;
        ph = (m_t - 1) % P;
        if (!rst && !finished) begin
            e_mdc = m_busy ? (ph >= H) : 1'b1;
            e_oe  = m_busy && (!m_rd || k < 46);
            check("R7 mdc", mdc, e_mdc);
            check("R6 mdio_oe", mdio_oe, e_oe);
            if (e_oe) check("R5 mdio_o", mdio_o, m_frame[63 - k]);
            case (host_sel)
                2'd0: begin
                    e_rd = {3'b000, !m_busy, m_op, m_phy, m_reg};
                    check("R2 command readback", host_rdata, e_rd);
                end
                2'd1: check("R1 transmit readback", host_rdata, m_wd);
                2'd2: check("R8 receive readback", host_rdata, m_rdreg);
                default: check("R1 unused readback", host_rdata, 16'h0);
            endcase
        end
        if (m_busy && m_rd && k >= 48) mdio_i = phy_val[15 - (k - 48)];
        else if (m_busy && m_rd && k == 47) mdio_i = 1'b0;
        else mdio_i = 1'b1;
    end

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 200000 && !finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", wd_cnt, 200000);
            summary();
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            #2ns;
            host_we  = 1'b0;
            host_sel = host_sel + 2'd1;
        end
    endtask

    task automatic hwr(logic [1:0] s, logic [15:0] d);
        @(posedge clk);
        #2ns;
        host_we = 1'b1; host_sel = s; host_wdata = d;
        @(posedge clk);
        #2ns;
        host_we = 1'b0;
    endtask

    task automatic peek(logic [1:0] s, output logic [15:0] v);
        host_sel = s;
        #1ns;
        v = host_rdata;
    endtask

    function automatic logic [15:0] cmd(logic [1:0] op, logic [4:0] phy, logic [4:0] rg);
        return {4'b0000, op, phy, rg};
    endfunction

    initial begin
        logic [15:0] v;
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        // R9 reset state
        check("R9 mdc after reset", mdc, 1'b1);
        check("R9 mdio_oe after reset", mdio_oe, 1'b0);
        peek(2'd0, v); check("R9 command after reset", v, 16'h1000);
        peek(2'd2, v); check("R9 receive after reset", v, 16'h0);
        peek(2'd1, v); check("R9 transmit after reset", v, 16'h0);

        // write frame
        hwr(2'd1, 16'hA5C3);
        hwr(2'd0, cmd(2'd1, 5'd5, 5'd17));
        peek(2'd0, v); check("R10 busy and R2 fields", v, 16'h04B1);
        check("R7 mdc low after accept", mdc, 1'b0);
        cyc(100);
        hwr(2'd0, cmd(2'd2, 5'd3, 5'd4));
        peek(2'd0, v); check("R4 busy command ignored", v, 16'h04B1);
        cyc(FL);
        peek(2'd0, v); check("R10 idle after write", v, 16'h14B1);

        // read frame
        phy_val = 16'h3C5A;
        hwr(2'd0, cmd(2'd2, 5'd31, 5'd0));
        cyc(FL / 2);
        peek(2'd2, v); check("R8 receive held mid-frame", v, 16'h0);
        cyc(FL / 2 + 4);
        peek(2'd2, v); check("R6 read data captured", v, 16'h3C5A);

        // reserved opcodes
        hwr(2'd0, cmd(2'd0, 5'd7, 5'd7));
        peek(2'd0, v); check("R3 opcode 0 ignored", v, 16'h1BE0);
        hwr(2'd0, cmd(2'd3, 5'd7, 5'd7));
        peek(2'd0, v); check("R3 opcode 3 ignored", v, 16'h1BE0);
        check("R3 mdc idle", mdc, 1'b1);

        // second read
        phy_val = 16'h8001;
        hwr(2'd0, cmd(2'd2, 5'd0, 5'd31));
        cyc(FL + 4);
        peek(2'd2, v); check("R8 second read", v, 16'h8001);

        // reset in the middle of a write
        hwr(2'd1, 16'h0001);
        hwr(2'd0, cmd(2'd1, 5'd21, 5'd10));
        cyc(FL / 3);
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        check("R9 mdc after mid reset", mdc, 1'b1);
        check("R9 oe after mid reset", mdio_oe, 1'b0);
        peek(2'd0, v); check("R9 command after mid reset", v, 16'h1000);

        hwr(2'd1, 16'h0001);
        hwr(2'd0, cmd(2'd1, 5'd21, 5'd10));
        cyc(FL + 4);
        peek(2'd0, v); check("R10 idle after final write", v, 16'h16AA);

        finished = 1;
        summary();
        $finish;
    end

endmodule